// File: doc/BRIEF.md
# Sized Integer ALU with Status Flag Register

This block performs integer addition, subtraction and the bitwise logic operations on operands of 8, 16 or 32 bits, and keeps a six-bit register of arithmetic status flags. The result is combinational from the inputs. The flag vector is captured on the rising clock edge whenever the enable input is high. Downstream conditional logic can then test carry, parity, half-carry, zero, sign and signed overflow from the last enabled operation.

Operands are trimmed to the selected size before use. Every flag is formed at that size, except parity, which always looks only at the lowest result byte. The add-with-carry and subtract-with-borrow operations take a single incoming carry bit. That bit normally comes from the block's own carry flag output, which makes multi-word arithmetic possible. The flag register has one piece of state and no sequencing beyond it. Its two conditions are HOLD, when the enable is low, and LOAD, when the enable is high.

Top module: `int_alu_flags`

## Requirements
- R1: The operation code selects the arithmetic as 0 = add, 1 = add plus carry-in, 2 = subtract, 3 = subtract minus carry-in. The result is taken modulo 2^size of the size-trimmed operands. The carry-in is ignored for codes 0 and 2.
- R2: The operation codes for the logical operations are 4 = AND, 5 = OR and 6 = XOR. Code 7 gives a zero result.
- R3: The size select uses 0 = 8 bits, 1 = 16 bits, and 2 or 3 = 32 bits. Result bits above the selected size are zero.
- R4: Flag bit 0 (carry) is set by an arithmetic operation on an unsigned carry out of the top bit of the selected size. On a subtraction, it is set when the minuend is smaller than the subtrahend plus the borrow-in.
- R5: Flag bit 1 (parity) is set when result bits 7..0 hold an even number of ones, at any size.
- R6: Flag bit 2 (half-carry) is set by an arithmetic operation on a carry or borrow out of bit 3.
- R7: Flag bit 3 (zero) is set when the sized result is zero. Flag bit 4 (sign) equals the top bit of the sized result.
- R8: Flag bit 5 (overflow) is set by an arithmetic operation when the exact signed result falls outside the two's-complement range of the selected size.
- R9: Logical operations and code 7 clear the carry, half-carry and overflow flags.
- R10: The flag register loads only on a rising edge with the enable high. With the enable low it holds its value.
- R11: An active-low asynchronous reset clears all six flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Loads the flag register on this edge |
| op | input | 3 | Operation code |
| size | input | 2 | Operand size select |
| a | input | 32 | First operand (minuend) |
| b | input | 32 | Second operand (subtrahend) |
| cf_in | input | 1 | Incoming carry or borrow |
| result | output | 32 | Sized result, zero above the size |
| flags | output | 6 | Registered flags {OF,SF,ZF,AF,PF,CF} |

## Verification
The flag register is the only state in the block. An error in the flag logic or in the register therefore appears at the flags output on the first rising edge after an enabled operation. An error in the hold path appears on the first edge with the enable low and different operands. A mistake in the size trimming or in the carry chain appears at once on the combinational result, and that same edge also corrupts the carry, half-carry and overflow flags. The bench sweeps every operation and both carry-in values over a stepped 8-bit operand grid, plus boundary values at 16 and 32 bits. It compares each result and each flag against an arithmetic model that uses exact signed and unsigned integers.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;
    localparam int IDX_W  = $clog2(DATA_W + 1);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_ADDC = 3'd1,
        OP_SUB  = 3'd2,
        OP_SUBB = 3'd3,
        OP_AND  = 3'd4,
        OP_OR   = 3'd5,
        OP_XOR  = 3'd6,
        OP_ZERO = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } alu_size_e;

    // packed from bit 5 down to bit 0
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic half;
        logic par;
        logic cry;
    } alu_flags_t;

    function automatic logic [DATA_W-1:0] size_mask(alu_size_e s);
        logic [DATA_W-1:0] m;
        unique case (s)
            SZ_BYTE: m = {{(DATA_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
            SZ_HALF: m = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
            default: m = {DATA_W{1'b1}};
        endcase
        return m;
    endfunction

    function automatic logic [IDX_W-1:0] top_bit(alu_size_e s);
        logic [IDX_W-1:0] i;
        unique case (s)
            SZ_BYTE: i = IDX_W'(BYTE_W - 1);
            SZ_HALF: i = IDX_W'(HALF_W - 1);
            default: i = IDX_W'(DATA_W - 1);
        endcase
        return i;
    endfunction

    function automatic logic is_logic_op(alu_op_e o);
        return o[2];
    endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
    import alu_pkg::*;
#(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] a_m,
    input  logic [W-1:0] b_m,
    input  logic         do_sub,
    input  logic         c_in,
    input  alu_size_e    size,
    output logic [W-1:0] sum,
    output logic         cry_out,
    output logic         half_out,
    output logic         ovf_out
);
    localparam int WX = W + 1;

    logic [WX-1:0]    wide;
    logic [IDX_W-1:0] msb;
    logic             sa, sb, sr;

    always_comb begin
        msb = top_bit(size);
        if (do_sub)
            wide = {1'b0, a_m} - {1'b0, b_m} - {{W{1'b0}}, c_in};
        else
            wide = {1'b0, a_m} + {1'b0, b_m} + {{W{1'b0}}, c_in};
        sum      = wide[W-1:0] & size_mask(size);
        cry_out  = wide[msb + IDX_W'(1)];
        half_out = a_m[4] ^ b_m[4] ^ wide[4];
        sa = a_m[msb];
        sb = b_m[msb];
        sr = wide[msb];
        if (do_sub)
            ovf_out = (sa != sb) && (sr != sa);
        else
            ovf_out = (sa == sb) && (sr != sa);
    end

    // R6
    half_zero_chk: assert final ((a_m[3:0] != 4'd0) || (b_m[3:0] != 4'd0) || c_in || !half_out);

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = alu_pkg::DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a_m,
    input  logic [W-1:0] b_m,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OP_AND:  res = a_m & b_m;
            OP_OR:   res = a_m | b_m;
            OP_XOR:  res = a_m ^ b_m;
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu_flaggen.sv
module alu_flaggen
    import alu_pkg::*;
#(
    parameter int W = alu_pkg::DATA_W
) (
    input  logic [W-1:0] res,
    input  alu_size_e    size,
    input  logic         logical,
    input  logic         cry_in,
    input  logic         half_in,
    input  logic         ovf_in,
    output alu_flags_t   nxt
);
    always_comb begin
        nxt.par  = ~^res[BYTE_W-1:0];
        nxt.zro  = (res == '0);
        nxt.sgn  = res[top_bit(size)];
        nxt.cry  = logical ? 1'b0 : cry_in;
        nxt.half = logical ? 1'b0 : half_in;
        nxt.ovf  = logical ? 1'b0 : ovf_in;
    end
endmodule

// File: rtl/int_alu_flags.sv
module int_alu_flags
    import alu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        en,
    input  logic [2:0]  op,
    input  logic [1:0]  size,
    input  logic [31:0] a,
    input  logic [31:0] b,
    input  logic        cf_in,
    output logic [31:0] result,
    output logic [5:0]  flags
);
    localparam int W = DATA_W;

    typedef enum logic {ST_HOLD, ST_LOAD} freg_state_e;

    alu_op_e     op_e;
    alu_size_e   sz_e;
    logic [W-1:0] a_m, b_m, arith_res, logic_res;
    logic        logical, do_sub, use_c;
    logic        a_cry, a_half, a_ovf;
    alu_flags_t  nxt, flags_q;
    freg_state_e st;

    always_comb begin
        op_e    = alu_op_e'(op);
        sz_e    = alu_size_e'(size);
        a_m     = a & size_mask(sz_e);
        b_m     = b & size_mask(sz_e);
        logical = is_logic_op(op_e);
        do_sub  = (op_e == OP_SUB) || (op_e == OP_SUBB);
        use_c   = (op_e == OP_ADDC) || (op_e == OP_SUBB);
        st      = en ? ST_LOAD : ST_HOLD;
    end

    alu_arith #(.W(W)) u_arith (
        .a_m(a_m), .b_m(b_m), .do_sub(do_sub), .c_in(use_c & cf_in),
        .size(sz_e), .sum(arith_res), .cry_out(a_cry),
        .half_out(a_half), .ovf_out(a_ovf)
    );

    alu_logic #(.W(W)) u_logic (
        .op(op_e), .a_m(a_m), .b_m(b_m), .res(logic_res)
    );

    always_comb result = logical ? logic_res : arith_res;

    alu_flaggen #(.W(W)) u_flags (
        .res(result), .size(sz_e), .logical(logical),
        .cry_in(a_cry), .half_in(a_half), .ovf_in(a_ovf), .nxt(nxt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            unique case (st)
                ST_LOAD: flags_q <= nxt;
                ST_HOLD: flags_q <= flags_q;
            endcase
        end
    end

    always_comb flags = flags_q;

    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(flags));

    // R9
    logic_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en && op[2] |=> (flags[0] == 1'b0) && (flags[2] == 1'b0) && (flags[5] == 1'b0));

    // R7
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> flags[3] == ($past(result) == 32'd0));

    // R5
    parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> flags[1] == ~^$past(result[7:0]));

    // R3
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        size == 2'd0 |-> result[31:8] == 24'd0);

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> flags == 6'd0);

endmodule

// File: tb/int_alu_flags_bench.sv
`timescale 1ns/1ps
module int_alu_flags_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic [2:0]  op = '0;
    logic [1:0]  size = '0;
    logic [31:0] a = '0, b = '0;
    logic        cf_in = 1'b0;
    logic [31:0] result;
    logic [5:0]  flags;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    int_alu_flags u_int_alu_flags (
        .clk(clk), .rst_n(rst_n), .en(en), .op(op), .size(size),
        .a(a), .b(b), .cf_in(cf_in), .result(result), .flags(flags)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s op=%0d size=%0d a=%h b=%h c=%0d act=%h exp=%h",
                     tag, op, size, a, b, cf_in, act, exp);
        end
    endtask

    function automatic longint sx(longint v, int w);
        if (((v >> (w - 1)) & 1) != 0) return v - (longint'(1) << w);
        return v;
    endfunction

    // returns {OF,SF,ZF,AF,PF,CF, result}
    function automatic logic [37:0] model(int o, int sz, logic [31:0] x, logic [31:0] y, logic c);
        int w;
        longint m, am, bm, ci, r, sr, maxp, minn;
        logic cf, af, of, pf, zf, sf, arith;
        logic [7:0] lb;
        logic [31:0] r32;
        w = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m = (longint'(1) << w) - 1;
        am = longint'(x) & m;
        bm = longint'(y) & m;
        ci = (o == 1 || o == 3) ? longint'(c) : 0;
        arith = (o < 4);
        cf = 0; sr = 0;
        case (o)
            0, 1: begin r = am + bm + ci; cf = ((r >> w) & 1) != 0; sr = sx(am, w) + sx(bm, w) + ci; end
            2, 3: begin r = am - bm - ci; cf = (am < bm + ci); sr = sx(am, w) - sx(bm, w) - ci; end
            4: r = am & bm;
            5: r = am | bm;
            6: r = am ^ bm;
            default: r = 0;
        endcase
        r = r & m;
        maxp = (longint'(1) << (w - 1)) - 1;
        minn = -(longint'(1) << (w - 1));
        of = arith && (sr > maxp || sr < minn);
        af = arith && ((((am ^ bm ^ r) >> 4) & 1) != 0);
        if (!arith) cf = 0;
        lb = r[7:0];
        pf = ~^lb;
        zf = (r == 0);
        sf = ((r >> (w - 1)) & 1) != 0;
        r32 = r[31:0];
        return {of, sf, zf, af, pf, cf, r32};
    endfunction

    task automatic apply(int o, int sz, logic [31:0] x, logic [31:0] y, logic c);
        logic [37:0] e;
        @(negedge clk);
        op = 3'(o); size = 2'(sz); a = x; b = y; cf_in = c; en = 1'b1;
        e = model(o, sz, x, y, c);
        @(posedge clk);
        #1;
        if (o < 4) chk("R1 result", result, e[31:0]);
        else       chk("R2 result", result, e[31:0]);
        if (sz == 0) chk("R3 upper", {8'd0, result[31:8]}, 32'd0);
        if (sz == 1) chk("R3 upper", {16'd0, result[31:16]}, 32'd0);
        chk("R4 carry", {31'd0, flags[0]}, {31'd0, e[32]});
        chk("R5 parity", {31'd0, flags[1]}, {31'd0, e[33]});
        chk("R6 half", {31'd0, flags[2]}, {31'd0, e[34]});
        chk("R7 zero", {31'd0, flags[3]}, {31'd0, e[35]});
        chk("R7 sign", {31'd0, flags[4]}, {31'd0, e[36]});
        chk("R8 overflow", {31'd0, flags[5]}, {31'd0, e[37]});
        if (o >= 4) chk("R9 cleared", {29'd0, flags[5], flags[2], flags[0]}, 32'd0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(20 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] edge_v [8];
        logic [5:0] held;
        edge_v[0] = 32'h0000_0000; edge_v[1] = 32'h0000_0001;
        edge_v[2] = 32'h0000_7FFF; edge_v[3] = 32'h0000_8000;
        edge_v[4] = 32'h0000_FFFF; edge_v[5] = 32'h7FFF_FFFF;
        edge_v[6] = 32'h8000_0000; edge_v[7] = 32'hFFFF_FFFF;

        // R11: reset state
        #35;
        chk("R11 reset", {26'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // stepped 8-bit grid, junk in upper bits
        for (int o = 0; o < 8; o++)
            for (int c = 0; c < 2; c++)
                for (int x = 0; x < 256; x += 7)
                    for (int y = 0; y < 256; y += 11)
                        apply(o, 0, 32'hA5A5_0000 | 32'(x), 32'h5A00_0000 | 32'(y), c[0]);

        // 8-bit corners
        for (int o = 0; o < 4; o++) begin
            apply(o, 0, 32'h7F, 32'h01, 1'b1);
            apply(o, 0, 32'h80, 32'hFF, 1'b1);
            apply(o, 0, 32'hFF, 32'hFF, 1'b1);
            apply(o, 0, 32'h0F, 32'h01, 1'b0);
        end

        // 16 and 32 bit boundaries; size 3 behaves as 32
        for (int sz = 1; sz < 4; sz++)
            for (int o = 0; o < 8; o++)
                for (int c = 0; c < 2; c++)
                    for (int i = 0; i < 8; i++)
                        for (int j = 0; j < 8; j++)
                            apply(o, sz, edge_v[i] ^ 32'h1234_0000, edge_v[j], c[0]);

        // R10: hold with enable low
        apply(0, 0, 32'hFF, 32'h01, 1'b0);
        held = flags;
        @(negedge clk);
        en = 1'b0; op = 3'd4; a = 32'h0; b = 32'h0;
        @(posedge clk); #1;
        @(posedge clk); #1;
        chk("R10 hold", {26'd0, flags}, {26'd0, held});
        chk("R2 result live", result, 32'd0);

        // R11: reset during operation
        apply(2, 0, 32'h00, 32'h01, 1'b0);
        @(negedge clk);
        rst_n = 1'b0;
        #2;
        chk("R11 async clear", {26'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        en = 1'b0;
        @(posedge clk); #1;
        chk("R11 stays clear", {26'd0, flags}, 32'd0);

        finish_run();
    end
endmodule